// File: doc/BRIEF.md
# Frame Alignment Offset Meter

The meter measures how far an external frame-evaluation pulse lags the internal frame boundary, with half a bit-clock of resolution. It runs on a system clock at twice the bit-clock rate. A phase input marks whether the current system cycle falls in the high or the low half of the bit clock. The internal frame-start strobe clears a free-running offset counter. That counter advances once per full bit-clock period and stops at its maximum.

Software raises the start-evaluation control bit. The meter then waits for the next frame-start strobe. At the first qualifying edge of the frame-evaluation input it records the counter value and the current phase half, and it raises a completion flag. The result stays frozen until start-evaluation is withdrawn, which clears it. A mode input selects which edge qualifies: the falling edge in ST-BUS mode, or the rising edge in GCI mode. The result comes out as a 16-bit status word.

Top module: `frame_offset_meter`

## Requirements
- R1: Status bits 15..13 always read as zero.
- R2: After reset the status word is 0x0000.
- R3: Bit 12 (completion flag) becomes 1 when a qualifying edge is captured. While start-evaluation stays 1, the flag, the phase bit and the offset hold their values, and later edges have no effect on them.
- R4: Bit 11 (phase bit) holds the value of phase_i (1 = bit-clock high half, 0 = low half) in the cycle the qualifying edge is detected.
- R5: Bits 10..0 (offset, bit 10 MSB) hold the offset counter value at capture. The counter clears on a frame-start strobe and increments on every cycle with phase_i = 0 and no strobe. It saturates at 2047.
- R6: With gci_mode_i = 0 only a falling edge of fe_i qualifies. With gci_mode_i = 1 only a rising edge qualifies.
- R7: After start-evaluation rises, edges seen before the next frame-start strobe are ignored.
- R8: In the cycle after start-evaluation is 0, the flag, the phase bit and the offset are all 0.
- R9: If no qualifying edge arrives within a frame, the meter keeps waiting through later frame-start strobes with the flag at 0, and it captures the first qualifying edge that comes afterwards.
- R10: fe_i passes through a two-stage synchronizer. A qualifying change of fe_i sampled at rising edge N appears in the status word after rising edge N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the bit-clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fe_i | input | 1 | Frame-evaluation input (asynchronous) |
| start_eval_i | input | 1 | Start-evaluation control bit |
| gci_mode_i | input | 1 | Edge polarity select: 0 = falling (ST-BUS), 1 = rising (GCI) |
| phase_i | input | 1 | Bit-clock half marker: 1 = high half, 0 = low half |
| frame_start_i | input | 1 | Internal frame-start strobe, one system cycle wide |
| status_o | output | 16 | {3'b000, done, phase, offset[10:0]} |

## Verification
The assertions assume three things about the inputs. frame_start_i is a single-cycle pulse that falls in a cycle with phase_i = 1. phase_i alternates on every system cycle. The edge-polarity check also assumes gci_mode_i changes only while no edge is in flight. The stimulus keeps to these assumptions: one free-running driver toggles the phase and emits the strobe on a fixed odd system cycle. The mode and the frame-evaluation level change only while start-evaluation is low or the meter is already waiting.

// File: rtl/fom_pkg.sv
package fom_pkg;
  typedef enum logic [1:0] {
    EV_IDLE,
    EV_ARM,
    EV_MEAS,
    EV_HOLD
  } ev_state_e;
endpackage

// File: rtl/fom_edge_det.sv
module fom_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fe_i,
  input  logic rise_mode_i,
  output logic edge_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], fe_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign cur    = sync_q[LAST];
  assign edge_o = rise_mode_i ? (cur & ~prev_q) : (~cur & prev_q);

  // same-polarity edges need two level changes, so they cannot be back to back
  p_no_double_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (!edge_o || rise_mode_i != $past(rise_mode_i)))
    else $error("double edge");
endmodule

// File: rtl/fom_offset_cnt.sv
module fom_offset_cnt #(
  parameter int OFS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             phase_i,
  output logic [OFS_W-1:0] cnt_o
);
  localparam logic [OFS_W-1:0] CNT_MAX = '1;

  logic [OFS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (frame_start_i)                cnt_q <= '0;
    else if (!phase_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_clear_on_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> cnt_o == '0)
    else $error("counter not cleared");

  p_saturate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !frame_start_i) |=> cnt_o == CNT_MAX)
    else $error("counter wrapped");
endmodule

// File: rtl/fom_eval_ctrl.sv
module fom_eval_ctrl
  import fom_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             frame_start_i,
  input  logic             edge_i,
  input  logic             phase_i,
  input  logic [OFS_W-1:0] cnt_i,
  output logic             done_o,
  output logic             phase_o,
  output logic [OFS_W-1:0] ofs_o
);
  ev_state_e        state_q;
  logic             done_q;
  logic             phase_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EV_IDLE;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
      ofs_q   <= '0;
    end else if (!start_i) begin
      state_q <= EV_IDLE;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
      ofs_q   <= '0;
    end else begin
      unique case (state_q)
        EV_IDLE: state_q <= EV_ARM;
        EV_ARM:  if (frame_start_i) state_q <= EV_MEAS;
        EV_MEAS: if (edge_i) begin
          state_q <= EV_HOLD;
          done_q  <= 1'b1;
          phase_q <= phase_i;
          ofs_q   <= cnt_i;
        end
        default: ;
      endcase
    end
  end

  assign done_o  = done_q;
  assign phase_o = phase_q;
  assign ofs_o   = ofs_q;

  p_clear_on_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && !phase_o && ofs_o == '0))
    else $error("result not cleared");

  p_hold_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (done_o && $stable(ofs_o) && $stable(phase_o)))
    else $error("result changed while held");

  p_armed_no_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == EV_ARM && !frame_start_i) |=> !done_o)
    else $error("done before frame start");

  p_done_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(edge_i && state_q == EV_MEAS))
    else $error("done without edge");
endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
  parameter int OFS_W       = 11,
  parameter int SYNC_STAGES = 2,
  localparam int STAT_W     = OFS_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fe_i,
  input  logic              start_eval_i,
  input  logic              gci_mode_i,
  input  logic              phase_i,
  input  logic              frame_start_i,
  output logic [STAT_W-1:0] status_o
);
  logic             edge_hit;
  logic [OFS_W-1:0] cnt;
  logic             done;
  logic             cap_phase;
  logic [OFS_W-1:0] ofs;

  fom_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fe_i       (fe_i),
    .rise_mode_i(gci_mode_i),
    .edge_o     (edge_hit)
  );

  fom_offset_cnt #(.OFS_W(OFS_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .phase_i      (phase_i),
    .cnt_o        (cnt)
  );

  fom_eval_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_eval_i),
    .frame_start_i(frame_start_i),
    .edge_i       (edge_hit),
    .phase_i      (phase_i),
    .cnt_i        (cnt),
    .done_o       (done),
    .phase_o      (cap_phase),
    .ofs_o        (ofs)
  );

  assign status_o = {3'b000, done, cap_phase, ofs};

  p_done_needs_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[OFS_W+1] |-> $past(start_eval_i))
    else $error("done without start");
endmodule

// File: tb/frame_offset_meter_tb.sv
module frame_offset_meter_tb_top;
  localparam int CLK_P     = 10;
  localparam int FRAME_SYS = 128;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fe = 1'b1;
  logic        start = 1'b0;
  logic        gci = 1'b0;
  logic        phase = 1'b0;
  logic        fs = 1'b0;
  logic [15:0] status;

  bit fs_en = 1'b1;
  bit finished = 1'b0;
  int tcnt = 0;
  int checks = 0;
  int errors = 0;

  // reference model state
  int unsigned h[$] = '{0, 0, 0};
  int m_state = 0;
  int m_cnt = 0;
  int m_done = 0;
  int m_ph = 0;
  int m_ofs = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_offset_meter dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .fe_i         (fe),
    .start_eval_i (start),
    .gci_mode_i   (gci),
    .phase_i      (phase),
    .frame_start_i(fs),
    .status_o     (status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      h = '{0, 0, 0};
      m_state = 0; m_cnt = 0; m_done = 0; m_ph = 0; m_ofs = 0;
    end else begin
      automatic bit e = gci ? (h[1] == 1 && h[2] == 0) : (h[1] == 0 && h[2] == 1);
      if (!start) begin
        m_state = 0; m_done = 0; m_ph = 0; m_ofs = 0;
      end else if (m_state == 0) m_state = 1;
      else if (m_state == 1) begin
        if (fs) m_state = 2;
      end else if (m_state == 2 && e) begin
        m_state = 3; m_done = 1; m_ph = phase; m_ofs = m_cnt;
      end
      if (fs) m_cnt = 0;
      else if (!phase && m_cnt < 2047) m_cnt++;
      h.push_front(fe);
      void'(h.pop_back());
    end
  end

  // free-running phase / strobe driver and per-cycle comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        check(status[15:13] == 3'b000, "R1", status[15:13], 0);
        check(status[12] == m_done, "R3", status[12], m_done);
        check(status[11] == m_ph, "R4", status[11], m_ph);
        check(status[10:0] == m_ofs, "R5", status[10:0], m_ofs);
      end
      tcnt++;
      phase <= tcnt[0];
      fs    <= fs_en && (tcnt % FRAME_SYS == 1);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fs;
    do @(posedge clk); while (fs !== 1'b1);
    cycles(6);
  endtask

  // drive fe so that it is first sampled in a cycle with phase == p
  task automatic drive_fe(input bit p, input bit v);
    do @(posedge clk); while (phase == p);
    @(negedge clk);
    fe <= v;
  endtask

  task automatic stop_eval;
    @(negedge clk); start <= 1'b0;
    cycles(2);
    check(status == 16'h0000, "R8", status, 0);
  endtask

  initial begin
    cycles(3);
    check(status == 16'h0000, "R2", status, 0);
    rst_ni <= 1'b1;
    cycles(2);
    check(status == 16'h0000, "R2", status, 0);

    // ST-BUS falling edge in the high half
    gci <= 1'b0; fe <= 1'b1; cycles(4);
    start <= 1'b1;
    wait_fs;
    cycles(20);
    drive_fe(1'b1, 1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(status[12] == 1'b0, "R10", status[12], 0);
    @(posedge clk); @(negedge clk);
    check(status[12] == 1'b1, "R10", status[12], 1);
    check(status[11] == 1'b1, "R4", status[11], 1);
    check(status[10:0] == m_ofs && m_ofs > 0, "R5", status[10:0], m_ofs);
    begin
      automatic int held = status;
      drive_fe(1'b0, 1'b1); cycles(5);
      drive_fe(1'b1, 1'b0); cycles(5);
      wait_fs; drive_fe(1'b0, 1'b1); drive_fe(1'b0, 1'b0); cycles(5);
      check(status == held, "R3", status, held);
    end
    stop_eval;

    // GCI: falling edge ignored, rising edge in the low half captured
    gci <= 1'b1; fe <= 1'b1; cycles(6);
    start <= 1'b1;
    wait_fs;
    drive_fe(1'b0, 1'b0); cycles(6);
    check(status[12] == 1'b0, "R6", status[12], 0);
    cycles(10);
    drive_fe(1'b0, 1'b1); cycles(5);
    check(status[12] == 1'b1, "R6", status[12], 1);
    check(status[11] == 1'b0, "R4", status[11], 0);
    stop_eval;

    // edges before the arming strobe are ignored
    gci <= 1'b0; fe <= 1'b1; cycles(6);
    wait_fs; cycles(10);
    start <= 1'b1; cycles(4);
    drive_fe(1'b1, 1'b0); cycles(6);
    check(status[12] == 1'b0, "R7", status[12], 0);
    fe <= 1'b1;
    wait_fs;
    drive_fe(1'b0, 1'b0); cycles(5);
    check(status[12] == 1'b1, "R7", status[12], 1);
    stop_eval;

    // no edge for two frames, then capture
    fe <= 1'b1; cycles(4);
    start <= 1'b1;
    wait_fs; wait_fs; wait_fs;
    check(status[12] == 1'b0, "R9", status[12], 0);
    drive_fe(1'b1, 1'b0); cycles(5);
    check(status[12] == 1'b1, "R9", status[12], 1);
    check(status[10:0] < FRAME_SYS / 2, "R9", status[10:0], FRAME_SYS / 2);
    stop_eval;

    // saturation with strobes withheld
    fe <= 1'b1; cycles(4);
    start <= 1'b1;
    wait_fs;
    fs_en = 1'b0;
    cycles(4300);
    drive_fe(1'b1, 1'b0); cycles(5);
    check(status[12] == 1'b1, "R5", status[12], 1);
    check(status[10:0] == 11'd2047, "R5", status[10:0], 2047);
    fs_en = 1'b1;
    stop_eval;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule